// File: doc/BRIEF.md
# SPI Controller Register and FIFO Front End

This block is the processor-facing half of an SPI controller. It decodes word-indexed register accesses and holds the configuration words that the serial engine consumes. It also owns two word-wide FIFOs, eight entries deep by default, one for each direction. The status flags, the pending interrupt sources, their enable mask and a single interrupt line live here as well. The serial engine that shifts the bits and generates the clock sits outside. It takes transmit words through a valid/ready handshake and hands received words back through a one-cycle valid pulse, with no backpressure.

A single data location serves both directions: writing it queues a word for transmission, and reading it dequeues the oldest received word. One control word carries both FIFO thresholds and the two flush strobes. Pending interrupt sources are cleared by writing ones. A source is raised when a FIFO level crosses its threshold, when the engine reports a finished transfer, or when a received word is lost because the receive FIFO is full.

The bus is a simple single-cycle port. A select, a write flag, a 4-bit word index (byte offset divided by four) and write data take effect at the next rising clock edge. Read data is combinational while select is high with write low. The word map is: 0 control, 1 clock setup, 2 transmit word setup, 3 receive word setup, 4 frame setup, 5 status, 6 interrupt enable, 7 interrupt pending/clear, 8 FIFO control, 9 data. Unmapped indices read 0.

Top module: `spiRegFront`

## Requirements
- R1: After reset every configuration word, the interrupt enable word, the pending word and the FIFO control word read 0, status reads 0x20, irq is 0 and txValid is 0.
- R2: Words 1 to 4 store and read back all 32 bits and drive cfgClock, cfgTxWord, cfgRxWord and cfgFrame; word 0 keeps only bit 0, which drives engEnable.
- R3: A write to word 9 queues the word for transmission; txValid is high only while engEnable is 1 and the transmit FIFO is not empty; the words leave on txData in write order, one per cycle in which txValid and txReady are both high.
- R4: When the transmit FIFO already holds eight words, a further write to word 9 is discarded, and status bit 5 (transmit not full) reads 0 while it is full.
- R5: A cycle with rxValid high stores rxData; reads of word 9 return received words oldest first, and status bit 0 (receive not empty) is 1 while any word is stored.
- R6: A word arriving while the receive FIFO holds eight words is dropped and sets pending bit 0 (overrun).
- R7: Reading word 9 while the receive FIFO is empty returns 0 and changes no FIFO state.
- R8: FIFO control bits 11:8 (transmit threshold) and 3:0 (receive threshold) read back as written; writing 1 to bit 12 empties the transmit FIFO and writing 1 to bit 4 empties the receive FIFO; bits 12 and 4 always read 0.
- R9: Pending bit 3 is set when the receive level rises from below to at or above the receive threshold; pending bit 4 is set when the transmit level falls from above to at or below the transmit threshold, or when xferDone is high; the pending word is read at word 7.
- R10: Writing word 7 clears each of pending bits 4, 3 and 0 whose write-data bit is 1 and leaves the others unchanged.
- R11: irq is high exactly when some pending bit is set whose matching bit in the enable word (word 6) is set.
- R12: Status bit 7 follows engBusy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 write, 0 read |
| busAddr | input | 4 | Word index of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data |
| irq | output | 1 | Masked interrupt request |
| engEnable | output | 1 | Engine enable (word 0 bit 0) |
| cfgClock | output | 32 | Clock setup word |
| cfgTxWord | output | 32 | Transmit word setup |
| cfgRxWord | output | 32 | Receive word setup |
| cfgFrame | output | 32 | Frame setup word |
| txValid | output | 1 | Transmit word available to the engine |
| txReady | input | 1 | Engine takes the transmit word |
| txData | output | 32 | Oldest transmit word |
| rxValid | input | 1 | Engine delivers a received word |
| rxData | input | 32 | Received word |
| engBusy | input | 1 | Engine is shifting |
| xferDone | input | 1 | Engine finished a transfer |

## Verification
The transmit path is exercised in three ways. First, a burst is loaded while the engine is disabled and then drained, which separates correct ordering and the full-FIFO drop from mere pass-through. Second, words stream through with the engine always ready, which exposes any off-by-one in the pop timing. Third, a stalled engine is flushed, which shows the flush really empties storage instead of only masking valid. On the receive side, nine back-to-back words are loaded with a threshold of three, so the threshold event and the overrun are raised together and can then be cleared one at a time. The unload order, the empty read and a receive flush follow. Every monitored transmit word is compared with a scoreboard queue filled by the write driver.

// File: rtl/spiRegPkg.sv
package spiRegPkg;
  localparam int IDX_W = 4;

  localparam logic [IDX_W-1:0] IDX_CTRL  = 4'd0;
  localparam logic [IDX_W-1:0] IDX_CLOCK = 4'd1;
  localparam logic [IDX_W-1:0] IDX_TXW   = 4'd2;
  localparam logic [IDX_W-1:0] IDX_RXW   = 4'd3;
  localparam logic [IDX_W-1:0] IDX_FRAME = 4'd4;
  localparam logic [IDX_W-1:0] IDX_STAT  = 4'd5;
  localparam logic [IDX_W-1:0] IDX_IEN   = 4'd6;
  localparam logic [IDX_W-1:0] IDX_PEND  = 4'd7;
  localparam logic [IDX_W-1:0] IDX_FCTL  = 4'd8;
  localparam logic [IDX_W-1:0] IDX_DATA  = 4'd9;

  localparam int ST_BUSY = 7;
  localparam int ST_TXNF = 5;
  localparam int ST_RXNE = 0;

  localparam int PEND_W  = 5;
  localparam int PB_TX   = 4;
  localparam int PB_RX   = 3;
  localparam int PB_OVR  = 0;
  localparam logic [PEND_W-1:0] PEND_MASK = 5'b11001;

  localparam int FC_TXFLUSH = 12;
  localparam int FC_RXFLUSH = 4;
  localparam int THR_W      = 4;
  localparam int FC_TXTHR   = 8;
  localparam int FC_RXTHR   = 0;

  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic txFlush;
    logic rxFlush;
  } fifoCmdT;
endpackage

// File: rtl/spiRegFifo.sv
module spiRegFifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic [CNT_W-1:0] level,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdata  = mem[rdPtr];
  assign level  = count;

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + PTR_W'(1);
      if (doPop)  rdPtr <= rdPtr + PTR_W'(1);
      case ({doPush, doPop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0));
  p_empty_pop_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pop && empty && !push && !flush) |=> $stable(rdPtr) && (count == '0));
  p_full_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop && !flush) |=> $stable(wrPtr) && full);
endmodule

// File: rtl/spiRegDatapath.sv
module spiRegDatapath
  import spiRegPkg::*;
#(
  parameter int REG_W = 32,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoCmdT          cmd,
  input  logic [REG_W-1:0] wdata,
  input  logic             engEnable,
  output logic             txValid,
  input  logic             txReady,
  output logic [REG_W-1:0] txData,
  input  logic             rxValid,
  input  logic [REG_W-1:0] rxData,
  output logic [REG_W-1:0] rxHead,
  output logic [CNT_W-1:0] txLevel,
  output logic [CNT_W-1:0] rxLevel,
  output logic             txFull,
  output logic             rxEmpty,
  output logic             rxDrop
);
  logic txEmpty, rxFull;

  assign txValid = engEnable && !txEmpty;
  assign rxDrop  = rxValid && rxFull && !cmd.rxFlush;

  spiRegFifo #(.WIDTH(REG_W), .DEPTH(DEPTH)) uTxFifo (
    .clk(clk), .rstN(rstN), .flush(cmd.txFlush),
    .push(cmd.txPush), .pop(txValid && txReady),
    .wdata(wdata), .rdata(txData), .level(txLevel),
    .full(txFull), .empty(txEmpty)
  );

  spiRegFifo #(.WIDTH(REG_W), .DEPTH(DEPTH)) uRxFifo (
    .clk(clk), .rstN(rstN), .flush(cmd.rxFlush),
    .push(rxValid), .pop(cmd.rxPop),
    .wdata(rxData), .rdata(rxHead), .level(rxLevel),
    .full(rxFull), .empty(rxEmpty)
  );

  p_tx_gated_r3: assert property (@(posedge clk) disable iff (!rstN)
    !engEnable |-> !txValid);
endmodule

// File: rtl/spiRegCtrl.sv
module spiRegCtrl
  import spiRegPkg::*;
#(
  parameter int REG_W = 32,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWrite,
  input  logic [IDX_W-1:0] busAddr,
  input  logic [REG_W-1:0] busWdata,
  output logic [REG_W-1:0] busRdata,
  output logic             irq,
  output logic             engEnable,
  output logic [REG_W-1:0] cfgClock,
  output logic [REG_W-1:0] cfgTxWord,
  output logic [REG_W-1:0] cfgRxWord,
  output logic [REG_W-1:0] cfgFrame,
  input  logic             engBusy,
  input  logic             xferDone,
  output fifoCmdT          cmd,
  input  logic [REG_W-1:0] rxHead,
  input  logic [CNT_W-1:0] txLevel,
  input  logic [CNT_W-1:0] rxLevel,
  input  logic             txFull,
  input  logic             rxEmpty,
  input  logic             rxDrop
);
  logic wrAcc, rdAcc;
  logic [THR_W-1:0]  txThr, rxThr;
  logic [PEND_W-1:0] ienReg, pend, pendNext;
  logic [CNT_W-1:0]  prevTx, prevRx;
  logic txCross, rxCross, txSet, pendWr;

  assign wrAcc  = busSel && busWrite;
  assign rdAcc  = busSel && !busWrite;
  assign pendWr = wrAcc && (busAddr == IDX_PEND);

  always_comb begin
    cmd         = '0;
    cmd.txPush  = wrAcc && (busAddr == IDX_DATA);
    cmd.rxPop   = rdAcc && (busAddr == IDX_DATA);
    cmd.txFlush = wrAcc && (busAddr == IDX_FCTL) && busWdata[FC_TXFLUSH];
    cmd.rxFlush = wrAcc && (busAddr == IDX_FCTL) && busWdata[FC_RXFLUSH];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engEnable <= 1'b0;
      cfgClock  <= '0;
      cfgTxWord <= '0;
      cfgRxWord <= '0;
      cfgFrame  <= '0;
      ienReg    <= '0;
      txThr     <= '0;
      rxThr     <= '0;
    end else if (wrAcc) begin
      case (busAddr)
        IDX_CTRL:  engEnable <= busWdata[0];
        IDX_CLOCK: cfgClock  <= busWdata;
        IDX_TXW:   cfgTxWord <= busWdata;
        IDX_RXW:   cfgRxWord <= busWdata;
        IDX_FRAME: cfgFrame  <= busWdata;
        IDX_IEN:   ienReg    <= busWdata[PEND_W-1:0] & PEND_MASK;
        IDX_FCTL: begin
          txThr <= busWdata[FC_TXTHR +: THR_W];
          rxThr <= busWdata[FC_RXTHR +: THR_W];
        end
        default: ;
      endcase
    end
  end

  // Threshold crossings are detected against the level seen one cycle earlier.
  assign txCross = (CMP_W'(prevTx) > CMP_W'(txThr)) && (CMP_W'(txLevel) <= CMP_W'(txThr));
  assign rxCross = (CMP_W'(prevRx) < CMP_W'(rxThr)) && (CMP_W'(rxLevel) >= CMP_W'(rxThr));
  assign txSet   = txCross || xferDone;

  always_comb begin
    pendNext = pend;
    if (pendWr) pendNext = pend & ~(busWdata[PEND_W-1:0] & PEND_MASK);
    if (txSet)   pendNext[PB_TX]  = 1'b1;
    if (rxCross) pendNext[PB_RX]  = 1'b1;
    if (rxDrop)  pendNext[PB_OVR] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend   <= '0;
      prevTx <= '0;
      prevRx <= '0;
    end else begin
      pend   <= pendNext;
      prevTx <= txLevel;
      prevRx <= rxLevel;
    end
  end

  assign irq = |(pend & ienReg);

  always_comb begin
    busRdata = '0;
    if (rdAcc) begin
      case (busAddr)
        IDX_CTRL:  busRdata[0] = engEnable;
        IDX_CLOCK: busRdata = cfgClock;
        IDX_TXW:   busRdata = cfgTxWord;
        IDX_RXW:   busRdata = cfgRxWord;
        IDX_FRAME: busRdata = cfgFrame;
        IDX_STAT: begin
          busRdata[ST_BUSY] = engBusy;
          busRdata[ST_TXNF] = !txFull;
          busRdata[ST_RXNE] = !rxEmpty;
        end
        IDX_IEN:   busRdata[PEND_W-1:0] = ienReg;
        IDX_PEND:  busRdata[PEND_W-1:0] = pend;
        IDX_FCTL: begin
          busRdata[FC_TXTHR +: THR_W] = txThr;
          busRdata[FC_RXTHR +: THR_W] = rxThr;
        end
        IDX_DATA:  busRdata = rxEmpty ? '0 : rxHead;
        default:   busRdata = '0;
      endcase
    end
  end

  p_overrun_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxDrop |=> pend[PB_OVR]);
  p_done_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> pend[PB_TX]);
  p_w1c_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pendWr && busWdata[PB_OVR] && !rxDrop) |=> !pend[PB_OVR]);
  p_irq_needs_pend_r11: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (pend != '0) && (ienReg != '0));
  p_flush_reads_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && busAddr == IDX_FCTL) |-> !busRdata[FC_TXFLUSH] && !busRdata[FC_RXFLUSH]);
endmodule

// File: rtl/spiRegFront.sv
module spiRegFront
  import spiRegPkg::*;
#(
  parameter int REG_W = 32,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWrite,
  input  logic [IDX_W-1:0] busAddr,
  input  logic [REG_W-1:0] busWdata,
  output logic [REG_W-1:0] busRdata,
  output logic             irq,
  output logic             engEnable,
  output logic [REG_W-1:0] cfgClock,
  output logic [REG_W-1:0] cfgTxWord,
  output logic [REG_W-1:0] cfgRxWord,
  output logic [REG_W-1:0] cfgFrame,
  output logic             txValid,
  input  logic             txReady,
  output logic [REG_W-1:0] txData,
  input  logic             rxValid,
  input  logic [REG_W-1:0] rxData,
  input  logic             engBusy,
  input  logic             xferDone
);
  fifoCmdT          cmd;
  logic [REG_W-1:0] rxHead;
  logic [CNT_W-1:0] txLevel, rxLevel;
  logic             txFull, rxEmpty, rxDrop;

  spiRegCtrl #(.REG_W(REG_W), .DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq),
    .engEnable(engEnable), .cfgClock(cfgClock), .cfgTxWord(cfgTxWord),
    .cfgRxWord(cfgRxWord), .cfgFrame(cfgFrame),
    .engBusy(engBusy), .xferDone(xferDone), .cmd(cmd),
    .rxHead(rxHead), .txLevel(txLevel), .rxLevel(rxLevel),
    .txFull(txFull), .rxEmpty(rxEmpty), .rxDrop(rxDrop)
  );

  spiRegDatapath #(.REG_W(REG_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wdata(busWdata),
    .engEnable(engEnable), .txValid(txValid), .txReady(txReady),
    .txData(txData), .rxValid(rxValid), .rxData(rxData),
    .rxHead(rxHead), .txLevel(txLevel), .rxLevel(rxLevel),
    .txFull(txFull), .rxEmpty(rxEmpty), .rxDrop(rxDrop)
  );
endmodule

// File: tb/tb_spiRegFront.sv
module tb_spiRegFront;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_CTRL = 4'd0, A_CLOCK = 4'd1, A_TXW = 4'd2, A_RXW = 4'd3,
                         A_FRAME = 4'd4, A_STAT = 4'd5, A_IEN = 4'd6, A_PEND = 4'd7,
                         A_FCTL = 4'd8, A_DATA = 4'd9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [3:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irq, engEnable, txValid;
  logic [31:0] cfgClock, cfgTxWord, cfgRxWord, cfgFrame, txData;
  logic txReady = 1'b0, rxValid = 1'b0, engBusy = 1'b0, xferDone = 1'b0;
  logic [31:0] rxData = '0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [31:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spiRegFront dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq),
    .engEnable(engEnable), .cfgClock(cfgClock), .cfgTxWord(cfgTxWord),
    .cfgRxWord(cfgRxWord), .cfgFrame(cfgFrame), .txValid(txValid),
    .txReady(txReady), .txData(txData), .rxValid(rxValid), .rxData(rxData),
    .engBusy(engBusy), .xferDone(xferDone)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 v = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic expectReg(input string tag, input logic [3:0] a, input logic [31:0] e);
    logic [31:0] v;
    rdReg(a, v);
    checkEq(tag, v, e);
  endtask

  // Scoreboard driver: queue the word as expected output, then write it.
  task automatic sendTx(input logic [31:0] d);
    expQ.push_back(d);
    wrReg(A_DATA, d);
  endtask

  task automatic pushRx(input logic [31:0] d);
    @(negedge clk);
    rxValid = 1'b1; rxData = d;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor: every accepted transmit word must match the queue head.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rstN && txValid && txReady) begin
        checks++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R3 unexpected tx word actual=0x%08h expected=none", txData);
        end else begin
          logic [31:0] e;
          e = expQ.pop_front();
          if (txData !== e) begin
            fails++;
            $display("FAIL R3 tx order actual=0x%08h expected=0x%08h", txData, e);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1 reset state
    expectReg("R1 status", A_STAT, 32'h20);
    expectReg("R1 ctrl", A_CTRL, 32'h0);
    expectReg("R1 fctl", A_FCTL, 32'h0);
    expectReg("R1 pend", A_PEND, 32'h0);
    checkEq("R1 irq", {31'b0, irq}, 32'h0);
    checkEq("R1 txValid", {31'b0, txValid}, 32'h0);

    // R2 configuration words
    wrReg(A_CLOCK, 32'hA5A5_1234);
    wrReg(A_TXW, 32'h0000_0808);
    wrReg(A_RXW, 32'hDEAD_BEEF);
    wrReg(A_FRAME, 32'h0000_C000);
    wrReg(A_CTRL, 32'hFFFF_FFFF);
    expectReg("R2 clock", A_CLOCK, 32'hA5A5_1234);
    expectReg("R2 rxword", A_RXW, 32'hDEAD_BEEF);
    expectReg("R2 ctrl bit0 only", A_CTRL, 32'h1);
    checkEq("R2 cfgClock", cfgClock, 32'hA5A5_1234);
    checkEq("R2 cfgTxWord", cfgTxWord, 32'h0000_0808);
    checkEq("R2 cfgFrame", cfgFrame, 32'h0000_C000);
    checkEq("R2 engEnable", {31'b0, engEnable}, 32'h1);
    wrReg(A_CTRL, 32'h0);

    // R12 busy
    engBusy = 1'b1;
    expectReg("R12 busy", A_STAT, 32'hA0);
    engBusy = 1'b0;

    // R8 thresholds: rx 3, tx 0
    wrReg(A_FCTL, 32'h0000_0003);
    expectReg("R8 thresholds", A_FCTL, 32'h3);

    // R4 fill while disabled, two extra writes dropped
    for (int k = 0; k < 8; k++) sendTx(32'h1000 + k);
    wrReg(A_DATA, 32'hBAD0);
    wrReg(A_DATA, 32'hBAD1);
    expectReg("R4 full status", A_STAT, 32'h00);
    checkEq("R3 no valid while disabled", {31'b0, txValid}, 32'h0);
    txReady = 1'b1;
    wrReg(A_CTRL, 32'h1);
    idle(15);
    checkEq("R4 drained exactly eight", expQ.size(), 32'h0);
    expectReg("R4 not full again", A_STAT, 32'h20);
    expectReg("R9 tx threshold pend", A_PEND, 32'h10);
    wrReg(A_PEND, 32'h10);
    expectReg("R10 tx clear", A_PEND, 32'h0);

    // R3 streaming with the engine always ready
    for (int k = 0; k < 5; k++) sendTx(32'h2000 + 7 * k);
    idle(4);
    checkEq("R3 stream drained", expQ.size(), 32'h0);
    // R3 stalled then released
    txReady = 1'b0;
    for (int k = 0; k < 3; k++) sendTx(32'h3000 + k);
    checkEq("R3 valid while stalled", {31'b0, txValid}, 32'h1);
    txReady = 1'b1;
    idle(6);
    checkEq("R3 stall drained", expQ.size(), 32'h0);
    wrReg(A_PEND, 32'h1F);

    // R8 transmit flush
    txReady = 1'b0;
    for (int k = 0; k < 3; k++) wrReg(A_DATA, 32'h4000 + k);
    wrReg(A_FCTL, 32'h0000_1003);
    expectReg("R8 flush reads zero", A_FCTL, 32'h3);
    checkEq("R8 tx emptied", {31'b0, txValid}, 32'h0);
    txReady = 1'b1;
    idle(2);
    wrReg(A_PEND, 32'h1F);
    expectReg("R10 all cleared", A_PEND, 32'h0);

    // R5 R6 R9 receive burst of nine
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      rxValid = 1'b1; rxData = 32'h100 + k;
    end
    @(negedge clk);
    rxValid = 1'b0;
    idle(1);
    expectReg("R9 R6 pend rx+ovr", A_PEND, 32'h09);
    expectReg("R5 status not empty", A_STAT, 32'h21);
    wrReg(A_IEN, 32'h10);
    checkEq("R11 masked", {31'b0, irq}, 32'h0);
    wrReg(A_IEN, 32'h01);
    checkEq("R11 enabled", {31'b0, irq}, 32'h1);
    wrReg(A_PEND, 32'h08);
    expectReg("R10 partial clear", A_PEND, 32'h01);
    for (int k = 1; k <= 8; k++) expectReg("R5 rx order", A_DATA, 32'h100 + k);
    expectReg("R7 empty read", A_DATA, 32'h0);
    expectReg("R7 status after empty read", A_STAT, 32'h20);
    pushRx(32'h777);
    expectReg("R7 fifo intact", A_DATA, 32'h777);
    wrReg(A_PEND, 32'h01);
    checkEq("R11 cleared", {31'b0, irq}, 32'h0);

    // R8 receive flush
    pushRx(32'h55);
    pushRx(32'h66);
    wrReg(A_FCTL, 32'h0000_0013);
    expectReg("R8 rx flushed status", A_STAT, 32'h20);
    expectReg("R8 rx flushed data", A_DATA, 32'h0);

    // R9 transfer done
    wrReg(A_IEN, 32'h10);
    @(negedge clk);
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
    #1 checkEq("R9 done irq", {31'b0, irq}, 32'h1);
    expectReg("R9 done pend", A_PEND, 32'h10);

    idle(2);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule